// File: doc/BRIEF.md
# Smart LCD Parallel Bus Writer

This block issues single write cycles on an 8080-style parallel bus toward a smart LCD panel controller. A client presents one request at a time: a 16-bit word plus a flag saying whether the word is a command (a register index) or data (a register value). The block drives the data-select line and the data bus, waits a setup phase, pulses an active-low write strobe for one cycle, then waits a hold phase before it reports idle again.

Commands and data each have their own setup and hold counts, given in clock cycles on dedicated inputs. Typical panel settings are 3 setup and 3 hold cycles for commands, and 2 setup and 3 hold cycles for data. The block samples these counts when it accepts a request. A panel register write is two requests in sequence: the index as a command, then the value as data. The second request may be issued in the first cycle that busy is low.

Top module: `lcd_bus_writer`

## Requirements
- R1: After reset, busy is 0, lcd_wr_n is 1, lcd_dsel is 0 and lcd_bus is all zeros.
- R2: lcd_dsel is 0 for a command transfer (req_is_data = 0) and 1 for a data transfer (req_is_data = 1). It is valid from the first busy cycle through the end of the hold phase.
- R3: lcd_bus carries the accepted req_word from the first busy cycle through the end of the hold phase, and does not change while busy is 1.
- R4: The setup phase runs from the first busy cycle to the cycle before lcd_wr_n goes low. It lasts cmd_setup cycles for a command and dat_setup cycles for data. A count of 0 acts as 1.
- R5: lcd_wr_n is low for exactly one cycle per transfer and only while busy is 1.
- R6: The hold phase runs from the cycle after the strobe until busy falls. It lasts cmd_hold cycles for a command and dat_hold cycles for data. A count of 0 acts as 1.
- R7: busy rises in the cycle after a request is sampled with busy low.
- R8: A request sampled while busy is 1 is ignored. The ongoing transfer keeps its word, select level and timing, and the ignored word never appears on lcd_bus.
- R9: The timing inputs are sampled only when a request is accepted. Changing them during a transfer has no effect on that transfer.
- R10: A request presented in the first cycle that busy is 0 is accepted, so a command and a data transfer can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, accepted when busy is low |
| req_is_data | input | 1 | 1 = data transfer, 0 = command transfer |
| req_word | input | DATA_W | Word to send |
| cmd_setup | input | CNT_W | Command setup cycles |
| cmd_hold | input | CNT_W | Command hold cycles |
| dat_setup | input | CNT_W | Data setup cycles |
| dat_hold | input | CNT_W | Data hold cycles |
| busy | output | 1 | High while a transfer is in progress |
| lcd_dsel | output | 1 | Data-select line to the panel |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_bus | output | DATA_W | Parallel data bus |

## Verification
Let S and H be the selected setup and hold counts, each treated as at least 1. An accepted request shows busy one cycle later, with the bus and select already valid. The strobe falls S cycles after busy rises and lasts one cycle. Busy falls H cycles after the strobe ends. The bench drives and samples on the falling clock edge and walks the transfer one cycle at a time. It counts setup cycles until the strobe and hold cycles until busy falls, and compares each count with S and H taken from its own vector entry. It also checks the bus and select values in the strobe cycle and in every hold cycle.

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_is_data,
  input  logic [DATA_W-1:0] req_word,
  input  logic [CNT_W-1:0]  cmd_setup,
  input  logic [CNT_W-1:0]  cmd_hold,
  input  logic [CNT_W-1:0]  dat_setup,
  input  logic [CNT_W-1:0]  dat_hold,
  output logic              busy,
  output logic              lcd_dsel,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_bus
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, hold_q;
  logic [DATA_W-1:0] bus_q;
  logic             dsel_q;

  function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  wire              accept    = req && (st == S_IDLE);
  wire [CNT_W-1:0]  sel_setup = req_is_data ? dat_setup : cmd_setup;
  wire [CNT_W-1:0]  sel_hold  = req_is_data ? dat_hold  : cmd_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      hold_q <= '0;
      bus_q  <= '0;
      dsel_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_SETUP;
          cnt    <= last_idx(sel_setup);
          hold_q <= last_idx(sel_hold);
          bus_q  <= req_word;
          dsel_q <= req_is_data;
        end
        S_SETUP: if (cnt == '0) st <= S_STROBE;
                 else cnt <= cnt - 1'b1;
        S_STROBE: begin
          st  <= S_HOLD;
          cnt <= hold_q;
        end
        S_HOLD: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign lcd_wr_n = (st != S_STROBE);
  assign lcd_bus  = bus_q;
  assign lcd_dsel = dsel_q;

endmodule

// File: rtl/lcd_bus_writer_chk.sv
module lcd_bus_writer_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              req_is_data,
  input logic [CNT_W-1:0]  cmd_setup,
  input logic [CNT_W-1:0]  cmd_hold,
  input logic [CNT_W-1:0]  dat_setup,
  input logic [CNT_W-1:0]  dat_hold,
  input logic              busy,
  input logic              lcd_dsel,
  input logic              lcd_wr_n,
  input logic [DATA_W-1:0] lcd_bus
);

  logic [CNT_W:0]   run;
  logic [CNT_W-1:0] exp_s, exp_h;

  function automatic logic [CNT_W-1:0] atleast1(input logic [CNT_W-1:0] n);
    return (n == '0) ? 1 : n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      exp_s <= '0;
      exp_h <= '0;
    end else if (req && !busy) begin
      run   <= '0;
      exp_s <= atleast1(req_is_data ? dat_setup : cmd_setup);
      exp_h <= atleast1(req_is_data ? dat_hold  : cmd_hold);
    end else if (!lcd_wr_n) begin
      run <= '0;
    end else if (busy) begin
      run <= run + 1'b1;
    end
  end

  AST_STROBE_IN_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) !lcd_wr_n |-> busy);                 // R5
  AST_STROBE_ONE_CYC:  assert property (@(posedge clk) disable iff (!rst_n) !lcd_wr_n |=> lcd_wr_n);              // R5
  AST_BUS_STABLE:      assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(lcd_bus) && $stable(lcd_dsel)); // R3
  AST_BUSY_RISE:       assert property (@(posedge clk) disable iff (!rst_n) req && !busy |=> busy);               // R7
  AST_SETUP_LEN:       assert property (@(posedge clk) disable iff (!rst_n) $fell(lcd_wr_n) |-> run == {1'b0, exp_s}); // R4
  AST_HOLD_LEN:        assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run == {1'b0, exp_h});  // R6

endmodule

bind lcd_bus_writer lcd_bus_writer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/lcd_bus_writer_tb_top.sv
`timescale 1ns/1ps
module lcd_bus_writer_tb_top;
  logic        clk = 0, rst_n = 0, req = 0, req_is_data = 0;
  logic [15:0] req_word = '0;
  logic [3:0]  cmd_setup = 0, cmd_hold = 0, dat_setup = 0, dat_hold = 0;
  logic        busy, lcd_dsel, lcd_wr_n;
  logic [15:0] lcd_bus;
  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk = ~clk;

  lcd_bus_writer dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // {is_data, setup, hold, word}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 4'd3, 4'd3, 16'h0003},
    {1'b1, 4'd2, 4'd3, 16'h1038},
    {1'b0, 4'd1, 4'd1, 16'hA5A5},
    {1'b1, 4'd5, 4'd2, 16'h5A5A},
    {1'b0, 4'd0, 4'd0, 16'hFFFF},
    {1'b1, 4'd0, 4'd4, 16'h0000},
    {1'b0, 4'd7, 4'd0, 16'h8001},
    {1'b1, 4'd15, 4'd15, 16'h7FFE}
  };

  task automatic xfer(input bit is_d, input logic [15:0] w, input int s, input int h,
                      input bit inject, input string tag);
    int sc, hc, es, eh;
    es = (s == 0) ? 1 : s;
    eh = (h == 0) ? 1 : h;
    req = 1; req_is_data = is_d; req_word = w;
    if (is_d) begin dat_setup = 4'(s); dat_hold = 4'(h); cmd_setup = 4'd9; cmd_hold = 4'd9; end
    else      begin cmd_setup = 4'(s); cmd_hold = 4'(h); dat_setup = 4'd9; dat_hold = 4'd9; end
    @(negedge clk);
    req = 0;
    check(busy == 1, {tag, " R7 busy rise"}, busy, 1);
    sc = 0;
    while (lcd_wr_n && busy && sc < 40) begin
      sc++;
      if (inject && sc == 1) begin
        req = 1; req_is_data = ~is_d; req_word = ~w;
        cmd_setup = 4'd1; cmd_hold = 4'd1; dat_setup = 4'd1; dat_hold = 4'd1;
      end
      if (inject && sc == 2) req = 0;
      @(negedge clk);
    end
    req = 0;
    check(sc == es, {tag, " R4 setup cycles"}, sc, es);
    check(lcd_wr_n == 0, {tag, " R5 strobe low"}, lcd_wr_n, 0);
    check(lcd_bus == w, {tag, " R3 bus at strobe"}, lcd_bus, w);
    check(lcd_dsel == is_d, {tag, " R2 dsel at strobe"}, lcd_dsel, is_d);
    @(negedge clk);
    check(lcd_wr_n == 1, {tag, " R5 strobe one cycle"}, lcd_wr_n, 1);
    hc = 0;
    while (busy && hc < 40) begin
      if (lcd_bus != w || lcd_dsel != is_d || !lcd_wr_n)
        check(0, {tag, " R3 hold phase values"}, lcd_bus, w);
      hc++;
      @(negedge clk);
    end
    check(hc == eh, {tag, " R6 hold cycles"}, hc, eh);
    check(lcd_bus == w, {tag, " R8 bus after transfer"}, lcd_bus, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && lcd_wr_n == 1, "R1 reset busy/strobe", {busy, lcd_wr_n}, 2'b01);
    check(lcd_dsel == 0 && lcd_bus == 0, "R1 reset dsel/bus", lcd_bus, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 8; i++)
      xfer(VEC[i][24], VEC[i][15:0], int'(VEC[i][23:20]), int'(VEC[i][19:16]), 0, $sformatf("vec%0d", i));

    // R8 / R9: request and timing changes during a transfer are ignored
    xfer(0, 16'h1234, 4, 3, 1, "R8_R9 inject");

    // R10: register write as back-to-back command then data
    xfer(0, 16'h0021, 3, 3, 0, "R10 index");
    xfer(1, 16'h1017, 2, 3, 0, "R10 value");

    repeat (2) @(negedge clk);
    check(busy == 0 && lcd_wr_n == 1, "R5 idle strobe high", lcd_wr_n, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule